// File: doc/BRIEF.md
# Snooze Power-Down Sequencer

This block sequences a memory array's move into and out of a low-power doze state. A sleep request arrives with no timing relation to the clock. It is resynchronized, and a timed entry window is then stepped through before the doze state is reached. While dozing, the cycle controller's inputs are ignored, the data outputs are forced to high impedance and a low-power status flag is raised. When the request drops, the flag clears at once and a timed recovery window runs before normal cycles are accepted again.

Inside either window, deselects and reads still reach the cycle controller. A write is held back and flagged as an error in the cycle it is presented. If the request reverses direction inside a window, the window for the new direction restarts from its full length.

Top module: `snooze_seq`

## Requirements
- R1: After reset the block is awake: inputIgnore, outHiZ, lowPower and winErr are 0, and cycleGrant follows cycleReq.
- R2: sleepReq passes through a two-flop synchronizer. The entry window begins after the third rising edge, counting the edge that first samples sleepReq high.
- R3: The entry window lasts WIN_CYCLES (2) clock cycles and is followed by the doze state. In the doze state inputIgnore is 1 and cycleGrant is 0 whatever cycleReq is.
- R4: outHiZ is 1 in exactly the cycles spent in the doze state.
- R5: lowPower is 1 while dozing with the synchronized request high. It drops in the same cycle the synchronized request falls, one edge before the doze state is left.
- R6: Leaving the doze state starts a recovery window of WIN_CYCLES cycles, after which the block is awake again.
- R7: Inside either window, a request with cycleWrite=0 (read or deselect) is granted and winErr stays 0.
- R8: Inside either window, a request with cycleWrite=1 is not granted and winErr is 1 in that same cycle.
- R9: If the synchronized request reverses during a window, the window for the opposite direction starts at the next edge with its full length.
- R10: While awake or dozing, winErr is 0. While awake, cycleGrant equals cycleReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepReq | input | 1 | Sleep request, no timing relation to clk |
| cycleReq | input | 1 | A cycle is presented to the controller |
| cycleWrite | input | 1 | The presented cycle is a write (1) or read/deselect (0) |
| cycleGrant | output | 1 | Cycle passed to the controller |
| winErr | output | 1 | Write attempted inside an entry or recovery window |
| inputIgnore | output | 1 | Controller inputs are ignored (doze state) |
| outHiZ | output | 1 | Force data outputs to high impedance |
| lowPower | output | 1 | Low-power status flag |

## Verification
Two functions can land in the same cycle: a window can restart on a request reversal while a write is being presented, and lowPower can drop in the cycle where the doze state still forces outHiZ and ignores input. Both are provoked by sweeping every pair of high and low request lengths from one to eight cycles, with all four combinations of cycleReq and cycleWrite rotating underneath. Every cycle is judged against a cycle-counting model of the synchronizer and windows kept in the bench, so a write that lands on a restart edge must still be blocked and flagged.

// File: rtl/snooze_pkg.sv
package snooze_pkg;

  typedef enum logic [1:0] {
    PH_AWAKE = 2'd0,
    PH_ENTER = 2'd1,
    PH_DOZE  = 2'd2,
    PH_WAKE  = 2'd3
  } phase_t;

  // strobes from the sequencing control to the gating datapath
  typedef struct packed {
    logic doze;     // settled in the low-power state
    logic window;   // inside an entry or recovery window
    logic reqLive;  // synchronized sleep request level
  } strobe_t;

endpackage

// File: rtl/snooze_ctrl.sv
module snooze_ctrl
  import snooze_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_CYCLES  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sleepReq,
  output strobe_t strobe
);

  localparam int CNT_W = $clog2(WIN_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   reqSync;
  phase_t                 phase, phaseNxt;
  logic [CNT_W-1:0]       winCnt, winCntNxt;

  // resynchronizer chain for the unclocked request
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= sleepReq;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sleepReq};
      end
    end
  endgenerate

  assign reqSync = syncQ[SYNC_STAGES-1];

  always_comb begin
    phaseNxt  = phase;
    winCntNxt = winCnt;
    unique case (phase)
      PH_AWAKE: begin
        if (reqSync) begin
          phaseNxt  = PH_ENTER;
          winCntNxt = CNT_LOAD;
        end
      end
      PH_ENTER: begin
        if (!reqSync) begin
          phaseNxt  = PH_WAKE;       // reversal restarts the other way
          winCntNxt = CNT_LOAD;
        end else if (winCnt == '0) begin
          phaseNxt  = PH_DOZE;
        end else begin
          winCntNxt = winCnt - 1'b1;
        end
      end
      PH_DOZE: begin
        if (!reqSync) begin
          phaseNxt  = PH_WAKE;
          winCntNxt = CNT_LOAD;
        end
      end
      PH_WAKE: begin
        if (reqSync) begin
          phaseNxt  = PH_ENTER;
          winCntNxt = CNT_LOAD;
        end else if (winCnt == '0) begin
          phaseNxt  = PH_AWAKE;
        end else begin
          winCntNxt = winCnt - 1'b1;
        end
      end
      default: phaseNxt = PH_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_AWAKE;
      winCnt <= '0;
    end else begin
      phase  <= phaseNxt;
      winCnt <= winCntNxt;
    end
  end

  always_comb begin
    strobe.doze    = (phase == PH_DOZE);
    strobe.window  = (phase == PH_ENTER) || (phase == PH_WAKE);
    strobe.reqLive = reqSync;
  end

endmodule

// File: rtl/snooze_path.sv
module snooze_path
  import snooze_pkg::*;
(
  input  strobe_t strobe,
  input  logic    cycleReq,
  input  logic    cycleWrite,
  output logic    cycleGrant,
  output logic    winErr,
  output logic    inputIgnore,
  output logic    outHiZ,
  output logic    lowPower
);

  logic writeTry;

  assign writeTry = cycleReq && cycleWrite;

  always_comb begin
    inputIgnore = strobe.doze;
    outHiZ      = strobe.doze;
    lowPower    = strobe.doze && strobe.reqLive;
    winErr      = strobe.window && writeTry;
    cycleGrant  = cycleReq && !strobe.doze && !(strobe.window && cycleWrite);
  end

endmodule

// File: rtl/snooze_seq.sv
module snooze_seq
  import snooze_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_CYCLES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic cycleReq,
  input  logic cycleWrite,
  output logic cycleGrant,
  output logic winErr,
  output logic inputIgnore,
  output logic outHiZ,
  output logic lowPower
);

  strobe_t strobe;

  snooze_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .WIN_CYCLES (WIN_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sleepReq(sleepReq),
    .strobe  (strobe)
  );

  snooze_path u_path (
    .strobe     (strobe),
    .cycleReq   (cycleReq),
    .cycleWrite (cycleWrite),
    .cycleGrant (cycleGrant),
    .winErr     (winErr),
    .inputIgnore(inputIgnore),
    .outHiZ     (outHiZ),
    .lowPower   (lowPower)
  );

endmodule

// File: rtl/snooze_seq_chk.sv
module snooze_seq_chk (
  input logic clk,
  input logic rstN,
  input logic cycleReq,
  input logic cycleWrite,
  input logic cycleGrant,
  input logic winErr,
  input logic inputIgnore,
  input logic outHiZ,
  input logic lowPower
);

  AST_ERR_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    winErr |-> (cycleReq && cycleWrite && !cycleGrant)); // R8

  AST_DOZE_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    inputIgnore |-> !cycleGrant); // R3

  AST_LP_IMPLIES_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    lowPower |-> outHiZ); // R5

  AST_DOZE_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    inputIgnore |-> !winErr); // R10

  AST_READ_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (cycleReq && !cycleWrite && !inputIgnore) |-> cycleGrant); // R7

  AST_WAKE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(lowPower) && inputIgnore) |=> !inputIgnore); // R6

endmodule

bind snooze_seq snooze_seq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cycleReq   (cycleReq),
  .cycleWrite (cycleWrite),
  .cycleGrant (cycleGrant),
  .winErr     (winErr),
  .inputIgnore(inputIgnore),
  .outHiZ     (outHiZ),
  .lowPower   (lowPower)
);

// File: tb/sim_snooze_seq.sv
module sim_snooze_seq;

  localparam int WIN = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0;
  logic cycleReq = 1'b0;
  logic cycleWrite = 1'b0;
  logic cycleGrant, winErr, inputIgnore, outHiZ, lowPower;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  snooze_seq #(.SYNC_STAGES(2), .WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq),
    .cycleReq(cycleReq), .cycleWrite(cycleWrite),
    .cycleGrant(cycleGrant), .winErr(winErr),
    .inputIgnore(inputIgnore), .outHiZ(outHiZ), .lowPower(lowPower)
  );

  // bench expectation: 0 awake, 1 entry, 2 doze, 3 recovery
  logic m1 = 1'b0, m2 = 1'b0;
  int mPh = 0, mPrev = 0, mTick = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= 1'b0; m2 <= 1'b0; mPh <= 0; mPrev <= 0; mTick <= 0;
    end else begin
      m1 <= sleepReq;
      m2 <= m1;
      mPrev <= mPh;
      if (mPh == 0 && m2) begin mPh <= 1; mTick <= 0; end
      else if (mPh == 2 && !m2) begin mPh <= 3; mTick <= 0; end
      else if (mPh == 1) begin
        if (!m2) begin mPh <= 3; mTick <= 0; end
        else if (mTick == WIN - 1) mPh <= 2;
        else mTick <= mTick + 1;
      end else if (mPh == 3) begin
        if (m2) begin mPh <= 1; mTick <= 0; end
        else if (mTick == WIN - 1) mPh <= 0;
        else mTick <= mTick + 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkCycle();
    bit win;
    int eGrant, eErr;
    string ignTag, gTag;
    win    = (mPh == 1 || mPh == 3);
    eErr   = (win && cycleReq && cycleWrite) ? 1 : 0;
    eGrant = (cycleReq && mPh != 2 && !(win && cycleWrite)) ? 1 : 0;
    if ((mPh == 1 && mPrev == 3) || (mPh == 3 && mPrev == 1)) ignTag = "R9";
    else if (mPh == 1) ignTag = "R2";
    else if (mPh == 2) ignTag = "R3";
    else if (mPh == 3) ignTag = "R6";
    else ignTag = "R10";
    if (win) gTag = cycleWrite ? "R8" : "R7";
    else gTag = "R10";
    chk(ignTag, "inputIgnore", int'(inputIgnore), (mPh == 2) ? 1 : 0);
    chk("R4", "outHiZ", int'(outHiZ), (mPh == 2) ? 1 : 0);
    chk("R5", "lowPower", int'(lowPower), (mPh == 2 && m2) ? 1 : 0);
    chk(gTag, "cycleGrant", int'(cycleGrant), eGrant);
    chk(gTag, "winErr", int'(winErr), eErr);
  endtask

  int cyc = 0;

  task automatic step(input bit req);
    @(negedge clk);
    sleepReq   = req;
    cycleReq   = cyc[0] | cyc[2];
    cycleWrite = cyc[1];
    cyc++;
    #2;
    checkCycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cycleReq = 1'b1; cycleWrite = 1'b1;
    #2;
    chk("R1", "inputIgnore", int'(inputIgnore), 0);
    chk("R1", "outHiZ", int'(outHiZ), 0);
    chk("R1", "lowPower", int'(lowPower), 0);
    chk("R1", "winErr", int'(winErr), 0);
    chk("R1", "cycleGrant", int'(cycleGrant), 1);
    @(negedge clk);
    rstN = 1'b1;
    for (int hi = 1; hi <= 8; hi++) begin
      for (int lo = 1; lo <= 8; lo++) begin
        for (int k = 0; k < hi; k++) step(1'b1);
        for (int k = 0; k < lo; k++) step(1'b0);
        for (int k = 0; k < 8; k++) step(1'b0);
      end
    end
    // long doze hold, then wake
    for (int k = 0; k < 12; k++) step(1'b1);
    for (int k = 0; k < 8; k++) step(1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule